// File: doc/BRIEF.md
# Partial-Scan Test Sequencer

This block orchestrates a partial-scan test session on a single scan chain of `N_SFF` scanned flip-flops, in a design where the remaining flip-flops are left unscanned. It produces three controls for the rest of the chip:

- **Test-control line.** It selects shift or capture in the scan cells.
- **Scan-clock enable.** It gates the clock of the scanned flip-flops.
- **Functional-clock enable.** It gates the clock of every unscanned flip-flop. This enable is only raised on capture cycles, so unscanned state is frozen while the chain shifts.

A session starts with a chain-integrity flush and then applies `N_VEC` test vectors. During the flush the sequencer itself drives a repeating two-zeros, two-ones pattern into the chain. It compares what emerges at the chain tail against the same pattern delayed by the chain length, and keeps a sticky miscompare flag.

Each vector then consists of three steps:

1. A full scan-in fed from the tester.
2. A single capture cycle, during which the tester applies the primary-input vector.
3. A scan-out, which shares its shift cycles with the next vector's scan-in.

A final scan-out unloads the last captured state. Strobes tell the tester when to present a scan-in bit, when to present a primary-input vector, and when the chain tail carries a response bit. The number of scan-clock cycles in a session is fixed at `(N_VEC+2)*N_SFF + N_VEC + 4`.

Top module: `pscan_seq`

## Requirements
- R1: Whenever the test-control output is 1, the scan-clock enable is 1 and the functional-clock enable is 0, so unscanned flip-flops keep their value through every shift cycle.
- R2: A capture cycle has test-control 0, both clock enables 1 and the primary-input strobe 1. It lasts exactly one cycle, and a session contains exactly `N_VEC` such cycles.
- R3: A start pulse while idle begins a flush of exactly `N_SFF+4` shift cycles. In flush cycle i (counting from 0), the chain input is bit 1 of i, which gives 0,0,1,1 repeating. No scan-in or scan-out strobe is raised in these cycles.
- R4: Before each capture come exactly `N_SFF` shift cycles with the scan-in strobe at 1. In those cycles the chain input equals the tester's serial input. The first bit presented lands in the chain's tail cell.
- R5: After the last capture come exactly `N_SFF` shift cycles with the scan-out strobe at 1 and the scan-in strobe at 0. The tail bit seen in these cycles, first bit first, is the captured state from the tail cell toward the head.
- R6: The scan-out of vector k uses the same cycles as the scan-in of vector k+1, with both strobes at 1. This gives `(N_VEC-1)*N_SFF` overlapped cycles per session.
- R7: A session spans exactly `(N_VEC+2)*N_SFF + N_VEC + 4` cycles with the scan-clock enable at 1. It is followed by a one-cycle done pulse with both clock enables at 0, and the sequencer then returns to idle.
- R8: In flush cycle i with i ≥ `N_SFF`, the chain output is compared with bit 1 of (i − `N_SFF`). Any mismatch sets a sticky fail flag, which holds until the next accepted start clears it.
- R9: After synchronous reset, every control, strobe, done and fail output is 0.
- R10: A start pulse during a session is ignored; the session's clock budget and sequence are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a session when idle |
| tst_si | input | 1 | Serial scan-in data from the tester |
| chain_so | input | 1 | Tail output of the scan chain |
| test_ctl | output | 1 | 1 = shift, 0 = capture |
| scan_clk_en | output | 1 | Clock enable of scanned flip-flops |
| func_clk_en | output | 1 | Clock enable of unscanned flip-flops |
| chain_si | output | 1 | Serial input to the scan chain head |
| si_req | output | 1 | Tester must present a scan-in bit this cycle |
| pi_req | output | 1 | Tester must present the primary-input vector this cycle |
| so_strobe | output | 1 | Chain tail carries a response bit this cycle |
| done | output | 1 | One-cycle end-of-session pulse |
| flush_fail | output | 1 | Sticky chain-flush miscompare flag |

## Verification
Between two captures, the unloading of one vector's response and the loading of the next vector's stimulus happen in the same shift cycles. A bit shifted out at the tail and a bit shifted in at the head therefore share one clock edge.

The bench models the scan chain and an unscanned register itself. Each vector loads a distinct word, and the capture XORs in a distinct primary-input word. A scoreboard holds the expected response of every vector, and a monitor rebuilds each response from the tail bits taken under the scan-out strobe. Any slip between the scan-out and scan-in timing therefore shows up as a corrupted word. The bench also counts the cycles in which both strobes are raised.

// File: rtl/pscan_pkg.sv
package pscan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLUSH,
        ST_SHIFT,
        ST_CAPTURE,
        ST_DONE
    } seq_state_e;

    // Control word produced by the decoder each cycle
    typedef struct packed {
        logic test_ctl;
        logic scan_en;
        logic func_en;
        logic si_req;
        logic so_strobe;
        logic pi_req;
        logic done;
    } ctl_vec_t;

    // Flush pattern: 0,0,1,1 repeating, i.e. bit 1 of the cycle index
    function automatic logic flush_bit(input logic [31:0] idx);
        return idx[1];
    endfunction

    function automatic int unsigned session_clocks(input int unsigned nsff,
                                                   input int unsigned nvec);
        return (nvec + 2) * nsff + nvec + 4;
    endfunction

endpackage

// File: rtl/pscan_fsm.sv
module pscan_fsm
    import pscan_pkg::*;
#(
    parameter int N_SFF = 8,
    parameter int N_VEC = 3,
    localparam int CW = $clog2(N_SFF + 5),
    localparam int VW = $clog2(N_VEC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output seq_state_e    state,
    output logic [CW-1:0] bit_cnt,
    output logic [VW-1:0] vec_cnt
);

    localparam logic [CW-1:0] FLUSH_LAST = CW'(N_SFF + 3);
    localparam logic [CW-1:0] SHIFT_LAST = CW'(N_SFF - 1);
    localparam logic [VW-1:0] VEC_ALL    = VW'(N_VEC);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            vec_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    bit_cnt <= '0;
                    vec_cnt <= '0;
                    if (start) state <= ST_FLUSH;
                end
                ST_FLUSH: begin
                    if (bit_cnt == FLUSH_LAST) begin
                        bit_cnt <= '0;
                        state   <= ST_SHIFT;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (bit_cnt == SHIFT_LAST) begin
                        bit_cnt <= '0;
                        state   <= (vec_cnt == VEC_ALL) ? ST_DONE : ST_CAPTURE;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_CAPTURE: begin
                    vec_cnt <= vec_cnt + 1'b1;
                    state   <= ST_SHIFT;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pscan_decode.sv
module pscan_decode
    import pscan_pkg::*;
#(
    parameter int N_VEC = 3,
    localparam int VW = $clog2(N_VEC + 1)
) (
    input  seq_state_e    state,
    input  logic [VW-1:0] vec_cnt,
    output ctl_vec_t      ctl
);

    localparam logic [VW-1:0] VEC_ALL = VW'(N_VEC);

    always_comb begin
        ctl = '0;
        unique case (state)
            ST_FLUSH: begin
                ctl.test_ctl = 1'b1;
                ctl.scan_en  = 1'b1;
            end
            ST_SHIFT: begin
                ctl.test_ctl  = 1'b1;
                ctl.scan_en   = 1'b1;
                ctl.si_req    = (vec_cnt < VEC_ALL);
                ctl.so_strobe = (vec_cnt != '0);
            end
            ST_CAPTURE: begin
                ctl.scan_en = 1'b1;
                ctl.func_en = 1'b1;
                ctl.pi_req  = 1'b1;
            end
            ST_DONE: ctl.done = 1'b1;
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/pscan_flush_chk.sv
module pscan_flush_chk
    import pscan_pkg::*;
#(
    parameter int N_SFF = 8,
    localparam int CW = $clog2(N_SFF + 5)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          in_flush,
    input  logic [CW-1:0] bit_cnt,
    input  logic          chain_so,
    output logic          fail
);

    localparam logic [CW-1:0] FILL = CW'(N_SFF);

    logic [CW-1:0] lag;
    logic          exp_bit;
    logic          armed;

    // Expected tail bit is the pattern delayed by the chain length
    assign lag     = bit_cnt - FILL;
    assign exp_bit = flush_bit(32'(lag));
    assign armed   = in_flush && (bit_cnt >= FILL);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fail <= 1'b0;
        end else if (armed && (chain_so != exp_bit)) begin
            fail <= 1'b1;
        end
    end

endmodule

// File: rtl/pscan_seq.sv
module pscan_seq
    import pscan_pkg::*;
#(
    parameter int N_SFF = 8,
    parameter int N_VEC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tst_si,
    input  logic chain_so,
    output logic test_ctl,
    output logic scan_clk_en,
    output logic func_clk_en,
    output logic chain_si,
    output logic si_req,
    output logic pi_req,
    output logic so_strobe,
    output logic done,
    output logic flush_fail
);

    localparam int CW = $clog2(N_SFF + 5);
    localparam int VW = $clog2(N_VEC + 1);

    seq_state_e    state;
    logic [CW-1:0] bit_cnt;
    logic [VW-1:0] vec_cnt;
    ctl_vec_t      ctl;
    logic          in_flush;

    pscan_fsm #(.N_SFF(N_SFF), .N_VEC(N_VEC)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .state   (state),
        .bit_cnt (bit_cnt),
        .vec_cnt (vec_cnt)
    );

    pscan_decode #(.N_VEC(N_VEC)) u_dec (
        .state   (state),
        .vec_cnt (vec_cnt),
        .ctl     (ctl)
    );

    assign in_flush = (state == ST_FLUSH);

    pscan_flush_chk #(.N_SFF(N_SFF)) u_flush (
        .clk      (clk),
        .rst      (rst),
        .clear    ((state == ST_IDLE) && start),
        .in_flush (in_flush),
        .bit_cnt  (bit_cnt),
        .chain_so (chain_so),
        .fail     (flush_fail)
    );

    assign test_ctl    = ctl.test_ctl;
    assign scan_clk_en = ctl.scan_en;
    assign func_clk_en = ctl.func_en;
    assign si_req      = ctl.si_req;
    assign pi_req      = ctl.pi_req;
    assign so_strobe   = ctl.so_strobe;
    assign done        = ctl.done;

    // Chain head: own pattern in flush, tester data during scan-in
    assign chain_si = in_flush ? flush_bit(32'(bit_cnt))
                               : (ctl.si_req & tst_si);

endmodule

// File: rtl/pscan_seq_chk.sv
module pscan_seq_chk
    import pscan_pkg::*;
#(
    parameter int N_SFF = 8,
    parameter int N_VEC = 3
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic tst_si,
    input logic test_ctl,
    input logic scan_clk_en,
    input logic func_clk_en,
    input logic chain_si,
    input logic si_req,
    input logic pi_req,
    input logic done,
    input logic flush_fail
);

    localparam int unsigned BUDGET = session_clocks(N_SFF, N_VEC);

    int unsigned clk_tally;

    always_ff @(posedge clk) begin
        if (rst || done) clk_tally <= 0;
        else if (scan_clk_en) clk_tally <= clk_tally + 1;
    end

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
        test_ctl |-> (scan_clk_en && !func_clk_en)); // R1
    AST_CAPTURE_MODE: assert property (@(posedge clk) disable iff (rst)
        func_clk_en |-> (scan_clk_en && !test_ctl && pi_req)); // R2
    AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        func_clk_en |=> !func_clk_en); // R2
    AST_SCAN_IN_PATH: assert property (@(posedge clk) disable iff (rst)
        si_req |-> (chain_si == tst_si)); // R4
    AST_CLOCK_BUDGET: assert property (@(posedge clk) disable iff (rst)
        done |-> (clk_tally == BUDGET)); // R7
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> (!scan_clk_en && !func_clk_en)); // R7
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flush_fail && !start) |=> flush_fail); // R8

endmodule

bind pscan_seq pscan_seq_chk #(.N_SFF(N_SFF), .N_VEC(N_VEC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .tst_si      (tst_si),
    .test_ctl    (test_ctl),
    .scan_clk_en (scan_clk_en),
    .func_clk_en (func_clk_en),
    .chain_si    (chain_si),
    .si_req      (si_req),
    .pi_req      (pi_req),
    .done        (done),
    .flush_fail  (flush_fail)
);

// File: tb/sim_pscan_seq.sv
module sim_pscan_seq;

    localparam int N      = 8;
    localparam int NV     = 3;
    localparam int CLK_P  = 10;
    localparam int BUDGET = (NV + 2) * N + NV + 4;

    logic clk = 1'b0;
    logic rst, start, tst_si, chain_so;
    logic test_ctl, scan_clk_en, func_clk_en, chain_si;
    logic si_req, pi_req, so_strobe, done, flush_fail;

    always #(CLK_P/2) clk = ~clk;

    pscan_seq #(.N_SFF(N), .N_VEC(NV)) u0 (
        .clk(clk), .rst(rst), .start(start), .tst_si(tst_si),
        .chain_so(chain_so), .test_ctl(test_ctl), .scan_clk_en(scan_clk_en),
        .func_clk_en(func_clk_en), .chain_si(chain_si), .si_req(si_req),
        .pi_req(pi_req), .so_strobe(so_strobe), .done(done),
        .flush_fail(flush_fail)
    );

    int n_chk = 0, n_fail = 0;

    task automatic check(input bit ok, input string tag,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Bench model: scan chain, one unscanned register
    logic [N-1:0] chain;
    logic [N-1:0] pi_bus;
    int           unscanned;
    bit           stuck;
    assign chain_so = stuck ? 1'b1 : chain[N-1];

    always @(posedge clk) begin
        if (scan_clk_en) begin
            if (test_ctl) chain <= {chain[N-2:0], chain_si};
            else          chain <= chain ^ pi_bus;
        end
        if (func_clk_en) unscanned <= unscanned + 1;
    end

    // Cycle tallies at the clock edge
    int sc_cnt, fc_cnt, ov_cnt, bad_cap, si_cnt, so_cnt;
    always @(posedge clk) begin
        if (scan_clk_en) sc_cnt++;
        if (func_clk_en) fc_cnt++;
        if (si_req && so_strobe) ov_cnt++;
        if (func_clk_en && test_ctl) bad_cap++;
        if (si_req) si_cnt++;
        if (so_strobe) so_cnt++;
    end

    // Driver: serves strobes, pushes expected responses to the scoreboard
    logic [N-1:0] load_w [NV];
    logic [N-1:0] pi_w   [NV];
    logic [N-1:0] exp_q [$];
    bit           sb_en;
    int           vi, bi, vp, fidx, fp_err;

    always @(negedge clk) begin
        if (si_req) begin
            tst_si = load_w[vi][N-1-bi];
            bi++;
            if (bi == N) begin bi = 0; vi++; end
        end else begin
            tst_si = 1'b0;
        end
        if (pi_req) begin
            pi_bus = pi_w[vp];
            if (sb_en) exp_q.push_back(load_w[vp] ^ pi_w[vp]);
            vp++;
        end
        // Flush cycles: shift with no strobe (R3)
        if (test_ctl && !si_req && !so_strobe) begin
            if (chain_si != fidx[1]) fp_err++;
            fidx++;
        end
    end

    // Monitor: rebuilds responses from tail bits, compares with queue
    logic [N-1:0] acc;
    int           nb, sb_cmp;
    always @(negedge clk) begin
        if (so_strobe && sb_en) begin
            acc = {acc[N-2:0], chain_so};
            nb++;
            if (nb == N) begin
                nb = 0;
                sb_cmp++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 scoreboard underflow", acc, 0);
                end else begin
                    logic [N-1:0] e;
                    e = exp_q.pop_front();
                    check(acc == e, "R5/R6 scan-out word", acc, e);
                end
            end
        end
    end

    task automatic prep(input int seed, input bit stk, input bit sb);
        for (int k = 0; k < NV; k++) begin
            load_w[k] = N'(8'h5A ^ (k * 37 + seed));
            pi_w[k]   = N'(8'hC3 ^ (k * 91 + seed * 3));
        end
        stuck = stk; sb_en = sb;
        exp_q.delete();
        vi = 0; bi = 0; vp = 0; fidx = 0; fp_err = 0; nb = 0; sb_cmp = 0;
        sc_cnt = 0; fc_cnt = 0; ov_cnt = 0; bad_cap = 0; si_cnt = 0; so_cnt = 0;
        unscanned = 0;
    endtask

    // Returns 1 if done was seen
    task automatic run(input bit poke_mid, output bit ok);
        int cyc;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 0; ok = 1'b0;
        while (cyc < 1000) begin
            if (done) begin ok = 1'b1; break; end
            if (poke_mid && cyc == 20) start = 1'b1;   // R10: ignored
            else start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        if (!ok) check(1'b0, "watchdog R7", cyc, BUDGET);
    endtask

    task automatic common_checks(input string s);
        check(sc_cnt == BUDGET, {s, " R7 scan clock budget"}, sc_cnt, BUDGET);
        check(fc_cnt == NV, {s, " R2 capture count"}, fc_cnt, NV);
        check(bad_cap == 0, {s, " R2 capture with shift"}, bad_cap, 0);
        check(unscanned == NV, {s, " R1 unscanned held in shift"}, unscanned, NV);
        check(fidx == N + 4, {s, " R3 flush length"}, fidx, N + 4);
        check(fp_err == 0, {s, " R3 flush pattern"}, fp_err, 0);
        check(si_cnt == NV * N, {s, " R4 scan-in strobes"}, si_cnt, NV * N);
        check(so_cnt == NV * N, {s, " R5 scan-out strobes"}, so_cnt, NV * N);
        check(ov_cnt == (NV - 1) * N, {s, " R6 overlap cycles"}, ov_cnt, (NV - 1) * N);
    endtask

    initial begin
        bit ok;
        rst = 1'b1; start = 1'b0; tst_si = 1'b0; chain = '0; pi_bus = '0;
        prep(0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check({test_ctl, scan_clk_en, func_clk_en, si_req, pi_req, so_strobe,
               done, flush_fail} == 8'b0, "R9 reset outputs",
              {test_ctl, scan_clk_en, func_clk_en, si_req, pi_req, so_strobe,
               done, flush_fail}, 0);

        // Session 1: good chain, start re-pulsed mid-session (R10)
        prep(1, 1'b0, 1'b1);
        run(1'b1, ok);
        if (ok) begin
            common_checks("s1 R10");
            check(flush_fail == 1'b0, "s1 R8 clean flush", flush_fail, 0);
            check(sb_cmp == NV, "s1 R5 responses seen", sb_cmp, NV);
            @(negedge clk);
            check(!done && !scan_clk_en && !test_ctl, "R7 single done pulse",
                  {done, scan_clk_en, test_ctl}, 0);
        end

        // Session 2: chain tail stuck at 1
        prep(2, 1'b1, 1'b0);
        run(1'b0, ok);
        if (ok) begin
            check(flush_fail == 1'b1, "s2 R8 stuck chain detected", flush_fail, 1);
            check(sc_cnt == BUDGET, "s2 R7 budget", sc_cnt, BUDGET);
            repeat (5) @(negedge clk);
            check(flush_fail == 1'b1, "s2 R8 flag sticky", flush_fail, 1);
        end

        // Session 3: good chain, new data; flag must clear on start
        prep(7, 1'b0, 1'b1);
        run(1'b0, ok);
        if (ok) begin
            common_checks("s3");
            check(flush_fail == 1'b0, "s3 R8 cleared by start", flush_fail, 0);
            check(sb_cmp == NV, "s3 R4 responses seen", sb_cmp, NV);
            check(exp_q.size() == 0, "s3 R5 queue drained", exp_q.size(), 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule